// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block brings a mixed-signal device from reset to full operation in a fixed order. After a reset it waits in a low-power standby state. When the run bit is set it enters an internal startup phase that lets the oscillator settle. It then either enters normal operation directly or first soft-starts the boost regulator, depending on the boost-enable bit. During soft-start the regulator first runs in pulse-frequency modulation and then switches to pulse-width modulation.

All waits are counted in ticks of an external millisecond timebase. A single counter serves every wait and is cleared whenever the state changes. The controller reports its state on a mode output. It drives enables for the internal bias/oscillator blocks, for the user functions and for the boost regulator. It also drives a clear signal that the register file uses to load its reset values. A thermal shutdown flag drops the controller back into the startup state and holds it there. A low pulse on the reset pin is honoured only when it lasts long enough.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: `rst` high or `por_i` high puts the controller in the reset state (mode 0) at the next clock edge. This has priority over every other transition. In the reset state `reg_clr_o` is 1 and all four enables are 0.
- R2: A low level on `rst_pin_n` is taken as a reset only after it has stayed low for RST_MIN_CYC consecutive clock edges. The mode becomes 0 at the following edge. A shorter low pulse has no effect on the mode.
- R3: Once reset is released, the reset state moves to standby (mode 1) at the next edge. In standby all outputs are 0. The controller stays in standby while `active_bit` is 0, whatever `ms_tick`, `boost_req` and `therm_i` do.
- R4: When `active_bit` is 0 in any state other than reset, the mode is 1 at the next edge.
- R5: In standby with `active_bit` at 1, the controller enters startup (mode 2) at the next edge. In startup `bias_en_o` is 1 and the other enables are 0. At the WAIT_MS-th tick after entry it moves to boost PFM (mode 4) if `boost_req` is 1, and otherwise to normal (mode 5) with the boost off.
- R6: In normal with `boost_req` at 1 and the boost not running, the controller enters boost settle (mode 3) at the next edge. In boost settle `bias_en_o` and `func_en_o` are 1 and the boost is off. At the WAIT_MS-th tick after entry it moves to mode 4.
- R7: In mode 4 `boost_on_o` is 1 and `boost_pwm_o` is 0. At the PFM_MS-th tick after entry it moves to normal with `boost_on_o` and `boost_pwm_o` both 1. PWM is never entered from anywhere else.
- R8: `boost_req` at 0 in mode 3, 4 or 5 gives mode 5 with `boost_on_o` and `boost_pwm_o` at 0 at the next edge.
- R9: `therm_i` at 1 in mode 2, 3, 4 or 5 gives mode 2 at the next edge. The controller holds the wait counter at zero while the flag stays high, and a full WAIT_MS wait restarts once it clears.
- R10: Ticks counted in one state never carry into the next: every wait starts from zero on state entry.
- R11: `mode_o` encodes the state as 0 reset, 1 standby, 2 startup, 3 boost settle, 4 boost PFM, 5 normal. In modes 3, 4 and 5 `func_en_o` and `bias_en_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_i | input | 1 | Power-on reset flag, active high |
| rst_pin_n | input | 1 | External reset pin, active low, width filtered |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| active_bit | input | 1 | 1 leaves standby, 0 requests standby |
| boost_req | input | 1 | Boost regulator enable bit |
| therm_i | input | 1 | Thermal shutdown flag |
| mode_o | output | 3 | Current state code |
| bias_en_o | output | 1 | Enable for reference, bias and oscillator |
| func_en_o | output | 1 | Enable for user functions |
| boost_on_o | output | 1 | Boost regulator running |
| boost_pwm_o | output | 1 | 1 selects PWM, 0 selects PFM |
| reg_clr_o | output | 1 | Load reset values into the registers |

## Verification
The assertions assume that the control bits, the flags and the tick are synchronous to `clk` and stable across each rising edge. They also assume that `ms_tick` is a single-cycle pulse. The stimulus changes every input just after a falling edge. It sends each tick as one high cycle followed by at least one low cycle. The bench runs with short waits so that every state, every exit path and the counter-restart cases can be reached one by one, including a reset-pin pulse one cycle too short.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        PM_RESET   = 3'd0,
        PM_STBY    = 3'd1,
        PM_START   = 3'd2,
        PM_BSETTLE = 3'd3,
        PM_BPFM    = 3'd4,
        PM_NORMAL  = 3'd5
    } pm_state_e;

    typedef struct packed {
        logic bias_en;
        logic func_en;
        logic boost_on;
        logic boost_pwm;
        logic reg_clr;
    } pm_out_t;

    function automatic int pm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic pm_is_active(input pm_state_e s);
        return (s == PM_START) || (s == PM_BSETTLE) || (s == PM_BPFM) || (s == PM_NORMAL);
    endfunction

    function automatic pm_out_t pm_decode(input pm_state_e s, input logic run);
        pm_out_t o;
        o = '0;
        unique case (s)
            PM_RESET:   o.reg_clr = 1'b1;
            PM_STBY:    o = '0;
            PM_START:   o.bias_en = 1'b1;
            PM_BSETTLE: begin o.bias_en = 1'b1; o.func_en = 1'b1; end
            PM_BPFM:    begin o.bias_en = 1'b1; o.func_en = 1'b1; o.boost_on = 1'b1; end
            PM_NORMAL:  begin
                o.bias_en   = 1'b1;
                o.func_en   = 1'b1;
                o.boost_on  = run;
                o.boost_pwm = run;
            end
            default:    o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/pwrseq_rst_filt.sv
module pwrseq_rst_filt #(
    parameter int MIN_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic por_i,
    input  logic pin_n,
    output logic rst_req
);
    localparam int W = $clog2(MIN_CYC + 1);

    logic [W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || pin_n) begin
            low_cnt <= '0;
        end else if (low_cnt != W'(MIN_CYC)) begin
            low_cnt <= low_cnt + W'(1);
        end
    end

    assign rst_req = por_i || (low_cnt == W'(MIN_CYC));

endmodule

// File: rtl/pwrseq_ms_timer.sv
module pwrseq_ms_timer #(
    parameter int MAX_MS = 10,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick && (cnt != CW'(MAX_MS))) begin
            cnt <= cnt + CW'(1);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(MAX_MS)) else $error("wait counter out of range"); // R10

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int WAIT_MS = 10,
    parameter int PFM_MS  = 10,
    parameter int CW      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rst_req,
    input  logic          active_bit,
    input  logic          boost_req,
    input  logic          therm,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    output pm_state_e     state,
    output logic          boost_run,
    output logic          tmr_clr
);
    pm_state_e nxt;
    logic      run_nxt;
    logic      hold;
    logic      wait_done;
    logic      pfm_done;

    assign wait_done = tick && (cnt == CW'(WAIT_MS - 1));
    assign pfm_done  = tick && (cnt == CW'(PFM_MS - 1));

    always_comb begin
        nxt     = state;
        run_nxt = boost_run;
        hold    = 1'b0;
        if (rst_req) begin
            nxt     = PM_RESET;
            run_nxt = 1'b0;
        end else if (state == PM_RESET) begin
            nxt = PM_STBY;
        end else if (!active_bit) begin
            nxt     = PM_STBY;
            run_nxt = 1'b0;
        end else if (state == PM_STBY) begin
            nxt = PM_START;
        end else if (therm) begin
            nxt     = PM_START;
            run_nxt = 1'b0;
            hold    = 1'b1;
        end else begin
            unique case (state)
                PM_START: begin
                    if (wait_done) nxt = boost_req ? PM_BPFM : PM_NORMAL;
                end
                PM_BSETTLE: begin
                    if (!boost_req)     nxt = PM_NORMAL;
                    else if (wait_done) nxt = PM_BPFM;
                end
                PM_BPFM: begin
                    if (!boost_req) begin
                        nxt = PM_NORMAL;
                    end else if (pfm_done) begin
                        nxt     = PM_NORMAL;
                        run_nxt = 1'b1;
                    end
                end
                PM_NORMAL: begin
                    if (!boost_req)     run_nxt = 1'b0;
                    else if (!boost_run) nxt    = PM_BSETTLE;
                end
                default: nxt = PM_RESET;
            endcase
        end
    end

    assign tmr_clr = (nxt != state) || hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PM_RESET;
            boost_run <= 1'b0;
        end else begin
            state     <= nxt;
            boost_run <= run_nxt;
        end
    end

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> state == PM_RESET) else $error("reset not taken"); // R1
    AST_STBY_FORCED: assert property (@(posedge clk) disable iff (rst)
        (!rst_req && !active_bit && state != PM_RESET) |=> state == PM_STBY) else $error("standby not taken"); // R4
    AST_THERM_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        (!rst_req && active_bit && therm && pm_is_active(state)) |=> state == PM_START) else $error("thermal fallback missed"); // R9
    AST_PWM_AFTER_PFM: assert property (@(posedge clk) disable iff (rst)
        $rose(boost_run) |-> $past(state) == PM_BPFM) else $error("PWM without PFM phase"); // R7
    AST_PFM_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state == PM_BPFM && $past(state) != PM_BPFM) |-> ($past(state) == PM_START || $past(state) == PM_BSETTLE)) else $error("bad PFM entry"); // R6
    AST_STBY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == PM_STBY) |-> !boost_run) else $error("boost alive in standby"); // R3

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int WAIT_MS     = 10,
    parameter int PFM_MS      = 10,
    parameter int RST_MIN_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por_i,
    input  logic       rst_pin_n,
    input  logic       ms_tick,
    input  logic       active_bit,
    input  logic       boost_req,
    input  logic       therm_i,
    output logic [2:0] mode_o,
    output logic       bias_en_o,
    output logic       func_en_o,
    output logic       boost_on_o,
    output logic       boost_pwm_o,
    output logic       reg_clr_o
);
    localparam int MAX_MS = pm_max(WAIT_MS, PFM_MS);
    localparam int CW     = $clog2(MAX_MS + 1);

    logic          rst_req;
    logic          tmr_clr;
    logic          boost_run;
    logic [CW-1:0] cnt;
    pm_state_e     state;
    pm_out_t       outs;

    pwrseq_rst_filt #(.MIN_CYC(RST_MIN_CYC)) u_filt (
        .clk(clk), .rst(rst), .por_i(por_i), .pin_n(rst_pin_n), .rst_req(rst_req)
    );

    pwrseq_ms_timer #(.MAX_MS(MAX_MS), .CW(CW)) u_timer (
        .clk(clk), .rst(rst), .clr(tmr_clr), .tick(ms_tick), .cnt(cnt)
    );

    pwrseq_fsm #(.WAIT_MS(WAIT_MS), .PFM_MS(PFM_MS), .CW(CW)) u_fsm (
        .clk(clk), .rst(rst), .rst_req(rst_req), .active_bit(active_bit),
        .boost_req(boost_req), .therm(therm_i), .tick(ms_tick), .cnt(cnt),
        .state(state), .boost_run(boost_run), .tmr_clr(tmr_clr)
    );

    assign outs        = pm_decode(state, boost_run);
    assign mode_o      = state;
    assign bias_en_o   = outs.bias_en;
    assign func_en_o   = outs.func_en;
    assign boost_on_o  = outs.boost_on;
    assign boost_pwm_o = outs.boost_pwm;
    assign reg_clr_o   = outs.reg_clr;

    AST_PWM_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        boost_pwm_o |-> (boost_on_o && func_en_o)) else $error("PWM without boost"); // R7

endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
    localparam int WAIT = 3;
    localparam int PFM  = 2;
    localparam int MINC = 4;

    logic clk = 1'b0;
    logic rst, por, pin_n, tick, active, boost, therm;
    logic [2:0] mode;
    logic bias, func, bon, pwm, clr;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwr_seq_ctrl #(.WAIT_MS(WAIT), .PFM_MS(PFM), .RST_MIN_CYC(MINC)) i_pwr_seq_ctrl (
        .clk(clk), .rst(rst), .por_i(por), .rst_pin_n(pin_n), .ms_tick(tick),
        .active_bit(active), .boost_req(boost), .therm_i(therm),
        .mode_o(mode), .bias_en_o(bias), .func_en_o(func), .boost_on_o(bon),
        .boost_pwm_o(pwm), .reg_clr_o(clr)
    );

    // expected {mode, bias, func, boost_on, pwm, clr} from R1, R3, R5-R8, R11
    function automatic logic [7:0] expv(input int m, input bit run);
        logic [7:0] v;
        v = {3'(m), 5'b0};
        case (m)
            0: v[0] = 1'b1;
            2: v[4] = 1'b1;
            3: v[4:3] = 2'b11;
            4: v[4:2] = 3'b111;
            5: begin v[4:3] = 2'b11; v[2] = run; v[1] = run; end
            default: ;
        endcase
        return v;
    endfunction

    task automatic chk(input string req, input int m, input bit run);
        logic [7:0] act, exp;
        act = {mode, bias, func, bon, pwm, clr};
        exp = expv(m, run);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; @(negedge clk);
            tick = 1'b0; @(negedge clk);
        end
    endtask

    initial begin
        rst = 1; por = 0; pin_n = 1; tick = 0; active = 0; boost = 0; therm = 0;
        step(3);          chk("R1 reset state", 0, 0);
        rst = 0; step(1); chk("R3 to standby", 1, 0);
        boost = 1; therm = 1;
        ticks(5);         chk("R3 standby holds", 1, 0);
        boost = 0; therm = 0;
        active = 1; step(1); chk("R5 startup entry", 2, 0);
        ticks(WAIT-1);    chk("R5 startup waiting", 2, 0);
        ticks(1);         chk("R5 startup to normal", 5, 0);
        boost = 1; step(1); chk("R6 settle entry", 3, 0);
        ticks(WAIT-1);    chk("R6 settle waiting", 3, 0);
        ticks(1);         chk("R6 settle to PFM", 4, 0);
        ticks(PFM-1);     chk("R7 R10 PFM waiting", 4, 0);
        ticks(1);         chk("R7 PWM in normal", 5, 1);
        boost = 0; step(1); chk("R8 boost off in normal", 5, 0);
        boost = 1; step(1); chk("R6 re-enable", 3, 0);
        boost = 0; step(1); chk("R8 drop in settle", 5, 0);
        boost = 1; step(1); ticks(WAIT); chk("R6 PFM again", 4, 0);
        boost = 0; step(1); chk("R8 drop in PFM", 5, 0);
        therm = 1; step(1); chk("R9 thermal fallback", 2, 0);
        ticks(6);         chk("R9 held by thermal", 2, 0);
        therm = 0; boost = 1;
        ticks(WAIT-1);    chk("R9 wait restarted", 2, 0);
        ticks(1);         chk("R5 startup to PFM", 4, 0);
        ticks(PFM);       chk("R7 PWM after startup", 5, 1);
        therm = 1; step(1); therm = 0;
        ticks(WAIT-1);
        therm = 1; step(1); therm = 0;
        ticks(WAIT-1);    chk("R10 R9 counter cleared", 2, 0);
        ticks(1);         chk("R10 wait completes", 4, 0);
        active = 0; step(1); chk("R4 standby from PFM", 1, 0);
        active = 1; step(1); ticks(WAIT + PFM); chk("R4 resume to PWM", 5, 1);
        pin_n = 0; step(MINC-1); pin_n = 1; step(2);
        chk("R2 short pulse ignored", 5, 1);
        pin_n = 0; step(MINC); chk("R2 not yet reset", 5, 1);
        step(1);          chk("R2 pin reset", 0, 0);
        pin_n = 1; step(1); chk("R2 release delay", 0, 0);
        step(1);          chk("R3 after pin reset", 1, 0);
        step(1);          chk("R5 restart", 2, 0);
        por = 1; step(1); chk("R1 power-on reset", 0, 0);
        por = 0; step(1); chk("R3 after power-on reset", 1, 0);
        step(1); ticks(WAIT + PFM); chk("R11 full sequence", 5, 1);
        rst = 1; step(1); chk("R1 sync reset", 0, 0);
        rst = 0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule